// File: doc/BRIEF.md
# HI/LO Multiply-Accumulate and Divide Unit

This block keeps a pair of 32-bit result registers, HI and LO, and computes into them. It offers eight operations: a signed or unsigned 32x32 multiply, and signed or unsigned forms of multiply-add, multiply-subtract and divide. Each operation starts from two operands and a start strobe. A multiply produces its 64-bit product in one step. The upper half of the product goes to HI and the lower half goes to LO. The accumulate forms treat HI:LO as one 64-bit accumulator. They add the product to it, or subtract the product from it, and write back all 64 bits.

Division is iterative and resolves one quotient bit per cycle. While it runs, `busy` is high. When it ends, the quotient lands in LO, the remainder lands in HI, and `done` pulses for one cycle. A zero divisor gives the same timing but leaves both registers as they were. Software-visible moves use separate write enables and a shared data word. Both registers are always readable on their output ports.

Top module: `hilo_muldiv_unit`

## Requirements
- R1: After synchronous reset, `hi_out` and `lo_out` are zero and `busy` and `done` are low.
- R2: Opcode 0 multiplies the operands as signed values. Opcode 1 multiplies them as unsigned values. The upper 32 bits of the 64-bit product go to HI and the lower 32 bits go to LO.
- R3: Opcode 2 (signed) and opcode 3 (unsigned) add the 64-bit product to {HI,LO}. The 64-bit sum wraps modulo 2^64 and is written back.
- R4: Opcode 4 (signed) and opcode 5 (unsigned) subtract the 64-bit product from {HI,LO}. The 64-bit difference wraps modulo 2^64 and is written back.
- R5: A multiply opcode (0 to 5) accepted at a clock edge updates HI/LO at that edge. `done` is high for exactly the following cycle, and `busy` stays low.
- R6: Opcode 6 divides as signed values and opcode 7 divides as unsigned values. The quotient goes to LO and the remainder goes to HI. Signed quotients truncate toward zero, and the remainder takes the sign of the dividend.
- R7: After a divide is accepted, `busy` is high for exactly 32 cycles. In the cycle `busy` falls, HI/LO hold the result and `done` is high, for that one cycle only.
- R8: A divide whose divisor is zero has the R7 timing but leaves HI and LO unchanged.
- R9: The signed divide 0x80000000 / 0xFFFFFFFF gives LO = 0x80000000 and HI = 0.
- R10: A start of any opcode while `busy` is high is ignored. It does not change HI, LO, the running divide's result or its timing.
- R11: `hi_wr` and `lo_wr` load `wr_data` into HI or LO at the clock edge. When an operation result is written to the registers at the same edge, the result takes priority.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin the operation selected by `op` |
| op | input | 3 | Operation code (see R2 to R6) |
| src_a | input | 32 | First operand / dividend |
| src_b | input | 32 | Second operand / divisor |
| hi_wr | input | 1 | Load `wr_data` into HI |
| lo_wr | input | 1 | Load `wr_data` into LO |
| wr_data | input | 32 | Data for move-to writes |
| hi_out | output | 32 | Current HI register |
| lo_out | output | 32 | Current LO register |
| busy | output | 1 | Divide in progress |
| done | output | 1 | One-cycle completion pulse |

## Verification
An accumulator fault, such as a dropped carry between LO and HI or a wrong extension of an operand, appears on `hi_out` in the cycle right after the accepting edge. The sign and wrap vectors expose it there. A fault in the divider's partial remainder or iteration count stays hidden while `busy` is high. It shows only 32 cycles later, as a wrong quotient or remainder, or as a `busy` window whose length is not 32. A divider that latches a second start shows up as the result of the wrong operands, or as a lengthened window.

// File: rtl/hilo_pkg.sv
`timescale 1ns/1ps
package hilo_pkg;

    localparam int unsigned OP_W = 3;

    // Even codes are signed, odd codes are unsigned.
    typedef enum logic [OP_W-1:0] {
        OP_MUL_S = 3'd0,
        OP_MUL_U = 3'd1,
        OP_MAC_S = 3'd2,
        OP_MAC_U = 3'd3,
        OP_MSB_S = 3'd4,
        OP_MSB_U = 3'd5,
        OP_DIV_S = 3'd6,
        OP_DIV_U = 3'd7
    } hilo_op_e;

    typedef struct packed {
        logic is_div;
        logic is_signed;
        logic accum;
        logic subtract;
    } op_ctrl_t;

    function automatic op_ctrl_t decode_op(input hilo_op_e code);
        op_ctrl_t c;
        c.is_signed = ~code[0];
        c.is_div    = (code == OP_DIV_S) || (code == OP_DIV_U);
        c.accum     = (code == OP_MAC_S) || (code == OP_MAC_U) ||
                      (code == OP_MSB_S) || (code == OP_MSB_U);
        c.subtract  = (code == OP_MSB_S) || (code == OP_MSB_U);
        return c;
    endfunction

    function automatic logic op_is_div(input logic [OP_W-1:0] code);
        return decode_op(hilo_op_e'(code)).is_div;
    endfunction

endpackage

// File: rtl/hilo_mul_path.sv
`timescale 1ns/1ps
module hilo_mul_path
    import hilo_pkg::*;
#(
    parameter int unsigned W = 32
) (
    input  op_ctrl_t         ctrl,
    input  logic [W-1:0]     opa,
    input  logic [W-1:0]     opb,
    input  logic [2*W-1:0]   acc,
    output logic [2*W-1:0]   result
);
    localparam int unsigned PW = 2 * W;

    logic [PW-1:0] ext_a;
    logic [PW-1:0] ext_b;
    logic [PW-1:0] product;

    // Sign or zero extension to full width, so the low PW bits of the
    // product are correct for both interpretations.
    always_comb begin
        ext_a = ctrl.is_signed ? {{W{opa[W-1]}}, opa} : {{W{1'b0}}, opa};
        ext_b = ctrl.is_signed ? {{W{opb[W-1]}}, opb} : {{W{1'b0}}, opb};
        product = ext_a * ext_b;
    end

    always_comb begin
        if (!ctrl.accum)
            result = product;
        else if (ctrl.subtract)
            result = acc - product;
        else
            result = acc + product;
    end

endmodule

// File: rtl/hilo_div_core.sv
`timescale 1ns/1ps
module hilo_div_core #(
    parameter int unsigned W = 32
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         load,
    input  logic         is_signed,
    input  logic [W-1:0] dividend,
    input  logic [W-1:0] divisor,
    output logic         busy,
    output logic         last,
    output logic         by_zero,
    output logic [W-1:0] quot,
    output logic [W-1:0] rem
);
    localparam int unsigned CW = (W > 1) ? $clog2(W) : 1;
    localparam logic [CW-1:0] LAST_STEP = CW'(W - 1);

    logic [W-1:0]  rem_q, quo_q, dvs_q;
    logic [CW-1:0] cnt_q;
    logic          busy_q, neg_quo_q, neg_rem_q, zero_q;

    logic [W-1:0]  mag_a, mag_b;
    logic [W:0]    shifted;
    logic          fits;
    logic [W-1:0]  sub_lo, rem_n, quo_n;

    always_comb begin
        mag_a = (is_signed && dividend[W-1]) ? (~dividend + 1'b1) : dividend;
        mag_b = (is_signed && divisor[W-1])  ? (~divisor + 1'b1)  : divisor;
    end

    // One restoring step: shift in the next dividend bit, try the subtract.
    always_comb begin
        shifted = {rem_q, quo_q[W-1]};
        fits    = (shifted >= {1'b0, dvs_q});
        sub_lo  = shifted[W-1:0] - dvs_q;
        rem_n   = fits ? sub_lo : shifted[W-1:0];
        quo_n   = {quo_q[W-2:0], fits};
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rem_q     <= '0;
            quo_q     <= '0;
            dvs_q     <= '0;
            cnt_q     <= '0;
            busy_q    <= 1'b0;
            neg_quo_q <= 1'b0;
            neg_rem_q <= 1'b0;
            zero_q    <= 1'b0;
        end else if (load && !busy_q) begin
            rem_q     <= '0;
            quo_q     <= mag_a;
            dvs_q     <= mag_b;
            cnt_q     <= '0;
            busy_q    <= 1'b1;
            neg_quo_q <= is_signed && (dividend[W-1] ^ divisor[W-1]);
            neg_rem_q <= is_signed && dividend[W-1];
            zero_q    <= (divisor == '0);
        end else if (busy_q) begin
            rem_q <= rem_n;
            quo_q <= quo_n;
            cnt_q <= cnt_q + 1'b1;
            if (cnt_q == LAST_STEP)
                busy_q <= 1'b0;
        end
    end

    always_comb begin
        busy    = busy_q;
        last    = busy_q && (cnt_q == LAST_STEP);
        by_zero = zero_q;
        quot    = neg_quo_q ? (~quo_n + 1'b1) : quo_n;
        rem     = neg_rem_q ? (~rem_n + 1'b1) : rem_n;
    end

endmodule

// File: rtl/hilo_muldiv_unit.sv
`timescale 1ns/1ps
module hilo_muldiv_unit
    import hilo_pkg::*;
#(
    parameter int unsigned W = 32
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                start,
    input  logic [OP_W-1:0]     op,
    input  logic [W-1:0]        src_a,
    input  logic [W-1:0]        src_b,
    input  logic                hi_wr,
    input  logic                lo_wr,
    input  logic [W-1:0]        wr_data,
    output logic [W-1:0]        hi_out,
    output logic [W-1:0]        lo_out,
    output logic                busy,
    output logic                done
);
    op_ctrl_t        ctrl;
    logic            accept, mul_go, div_go;
    logic [2*W-1:0]  mul_res;
    logic            div_busy, div_last, div_zero;
    logic [W-1:0]    div_quot, div_rem;
    logic [W-1:0]    hi_q, lo_q;
    logic            done_q;

    always_comb begin
        ctrl   = decode_op(hilo_op_e'(op));
        accept = start && !div_busy;
        mul_go = accept && !ctrl.is_div;
        div_go = accept && ctrl.is_div;
    end

    hilo_mul_path #(.W(W)) u_mul (
        .ctrl   (ctrl),
        .opa    (src_a),
        .opb    (src_b),
        .acc    ({hi_q, lo_q}),
        .result (mul_res)
    );

    hilo_div_core #(.W(W)) u_div (
        .clk       (clk),
        .rst       (rst),
        .load      (div_go),
        .is_signed (ctrl.is_signed),
        .dividend  (src_a),
        .divisor   (src_b),
        .busy      (div_busy),
        .last      (div_last),
        .by_zero   (div_zero),
        .quot      (div_quot),
        .rem       (div_rem)
    );

    // Operation results win over move-to writes at the same edge.
    always_ff @(posedge clk) begin
        if (rst) begin
            hi_q   <= '0;
            lo_q   <= '0;
            done_q <= 1'b0;
        end else begin
            done_q <= mul_go || div_last;
            if (mul_go) begin
                hi_q <= mul_res[2*W-1:W];
                lo_q <= mul_res[W-1:0];
            end else if (div_last && !div_zero) begin
                hi_q <= div_rem;
                lo_q <= div_quot;
            end else begin
                if (hi_wr) hi_q <= wr_data;
                if (lo_wr) lo_q <= wr_data;
            end
        end
    end

    always_comb begin
        hi_out = hi_q;
        lo_out = lo_q;
        busy   = div_busy;
        done   = done_q;
    end

endmodule

// File: rtl/hilo_muldiv_chk.sv
`timescale 1ns/1ps
module hilo_muldiv_chk
    import hilo_pkg::*;
#(
    parameter int unsigned W = 32
) (
    input logic            clk,
    input logic            rst,
    input logic            start,
    input logic [OP_W-1:0] op,
    input logic [W-1:0]    src_b,
    input logic            hi_wr,
    input logic            lo_wr,
    input logic [W-1:0]    hi_out,
    input logic [W-1:0]    lo_out,
    input logic            busy,
    input logic            done
);
    localparam int unsigned CNT_W = $clog2(W + 1) + 1;

    logic [CNT_W-1:0] busy_cnt;
    logic             zero_div;

    always_ff @(posedge clk) begin
        if (rst) begin
            busy_cnt <= '0;
            zero_div <= 1'b0;
        end else begin
            busy_cnt <= busy ? busy_cnt + 1'b1 : '0;
            if (start && !busy && op_is_div(op))
                zero_div <= (src_b == '0);
        end
    end

    // R5: multiply completes in one step without raising busy
    a_r5_mul_one_step: assert property (@(posedge clk) disable iff (rst)
        (start && !busy && !op_is_div(op)) |=> (done && !busy));

    // R7: done is a single-cycle pulse
    a_r7_done_single: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

    // R7: done accompanies the end of a divide
    a_r7_done_at_end: assert property (@(posedge clk) disable iff (rst)
        $fell(busy) |-> done);

    // R7: busy window length
    a_r7_busy_window: assert property (@(posedge clk) disable iff (rst)
        $fell(busy) |-> (busy_cnt == CNT_W'(W)));

    // R10: registers hold while a divide runs, whatever start does
    a_r10_hi_hold: assert property (@(posedge clk) disable iff (rst)
        (busy && !hi_wr) |=> (!busy || $stable(hi_out)));
    a_r10_lo_hold: assert property (@(posedge clk) disable iff (rst)
        (busy && !lo_wr) |=> (!busy || $stable(lo_out)));

    // R8: zero divisor leaves the registers alone
    a_r8_zero_keeps: assert property (@(posedge clk) disable iff (rst)
        ($fell(busy) && zero_div && !$past(hi_wr) && !$past(lo_wr))
            |-> ($stable(hi_out) && $stable(lo_out)));

endmodule

bind hilo_muldiv_unit hilo_muldiv_chk #(.W(W)) u_chk (
    .clk    (clk),
    .rst    (rst),
    .start  (start),
    .op     (op),
    .src_b  (src_b),
    .hi_wr  (hi_wr),
    .lo_wr  (lo_wr),
    .hi_out (hi_out),
    .lo_out (lo_out),
    .busy   (busy),
    .done   (done)
);

// File: tb/hilo_muldiv_unit_test.sv
`timescale 1ns/1ps
module hilo_muldiv_unit_test;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        start = 1'b0;
    logic [2:0]  op = '0;
    logic [31:0] src_a = '0, src_b = '0;
    logic        hi_wr = 1'b0, lo_wr = 1'b0;
    logic [31:0] wr_data = '0;
    logic [31:0] hi_out, lo_out;
    logic        busy, done;

    int total = 0;
    int fails = 0;

    always #2.5 clk = ~clk;

    hilo_muldiv_unit uut (
        .clk(clk), .rst(rst), .start(start), .op(op),
        .src_a(src_a), .src_b(src_b), .hi_wr(hi_wr), .lo_wr(lo_wr),
        .wr_data(wr_data), .hi_out(hi_out), .lo_out(lo_out),
        .busy(busy), .done(done)
    );

    // {op, a, b, preset HI, preset LO}
    localparam int NV = 14;
    localparam logic [130:0] VEC [0:NV-1] = '{
        {3'd0, 32'h00000007, 32'hFFFFFFFD, 32'h00000000, 32'h00000000},
        {3'd0, 32'h80000000, 32'h80000000, 32'h11111111, 32'h22222222},
        {3'd1, 32'hFFFFFFFF, 32'hFFFFFFFF, 32'h00000000, 32'h00000000},
        {3'd1, 32'h12345678, 32'h9ABCDEF0, 32'h00000000, 32'h00000000},
        {3'd2, 32'hFFFFFFFE, 32'h00000005, 32'h00000000, 32'h00000010},
        {3'd3, 32'h00000001, 32'h00000001, 32'hFFFFFFFF, 32'hFFFFFFFF},
        {3'd2, 32'hFFFFFFFF, 32'h00000001, 32'h00000001, 32'h00000000},
        {3'd4, 32'h00000003, 32'h00000004, 32'h00000000, 32'h00000000},
        {3'd5, 32'hFFFFFFFF, 32'h00000001, 32'h00000001, 32'h00000000},
        {3'd6, 32'hFFFFFFF9, 32'h00000002, 32'h00000000, 32'h00000000},
        {3'd6, 32'h00000007, 32'hFFFFFFFE, 32'h00000000, 32'h00000000},
        {3'd7, 32'hFFFFFFFF, 32'h00000010, 32'h00000000, 32'h00000000},
        {3'd7, 32'h00000005, 32'h00000007, 32'h00000000, 32'h00000000},
        {3'd6, 32'hFFFFFFF8, 32'hFFFFFFFD, 32'h00000000, 32'h00000000}
    };

    // Reference computed from the requirements with wide arithmetic.
    function automatic logic [63:0] ref_model(input logic [2:0] code,
        input logic [31:0] a, input logic [31:0] b,
        input logic [31:0] hi, input logic [31:0] lo);
        logic signed [63:0] sa, sb, sq, sr;
        logic [63:0] ua, ub, prod, acc;
        sa = {{32{a[31]}}, a};
        sb = {{32{b[31]}}, b};
        ua = {32'h0, a};
        ub = {32'h0, b};
        acc = {hi, lo};
        prod = code[0] ? ua * ub : 64'(sa * sb);
        case (code)
            3'd0, 3'd1: return prod;
            3'd2, 3'd3: return acc + prod;
            3'd4, 3'd5: return acc - prod;
            default: begin
                if (b == 32'h0) return acc;
                if (code == 3'd6) begin
                    sq = sa / sb;
                    sr = sa % sb;
                    return {sr[31:0], sq[31:0]};
                end
                return {32'(ua % ub), 32'(ua / ub)};
            end
        endcase
    endfunction

    function automatic string req_of(input logic [2:0] code);
        case (code)
            3'd0, 3'd1: return "R2";
            3'd2, 3'd3: return "R3";
            3'd4, 3'd5: return "R4";
            default:    return "R6";
        endcase
    endfunction

    task automatic chk(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    task automatic preset(input logic [31:0] h, input logic [31:0] l);
        @(negedge clk);
        hi_wr = 1'b1; wr_data = h;
        @(negedge clk);
        hi_wr = 1'b0; lo_wr = 1'b1; wr_data = l;
        @(negedge clk);
        lo_wr = 1'b0;
    endtask

    // Returns at the falling edge right after the accepting rising edge.
    task automatic issue(input logic [2:0] code, input logic [31:0] a,
                         input logic [31:0] b);
        @(negedge clk);
        start = 1'b1; op = code; src_a = a; src_b = b;
        @(negedge clk);
        start = 1'b0;
    endtask

    // Counts busy cycles; returns at the falling edge where busy is low.
    task automatic wait_idle(output int cycles);
        cycles = 0;
        while (busy && cycles < 100) begin
            @(negedge clk);
            cycles++;
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        fails++;
        total++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("%0d/%0d checks passed", total - fails, total);
        $finish;
    end

    initial begin
        int cyc;
        logic [63:0] exp;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        // R1 reset state
        chk("R1", "hi", hi_out, 32'h0);
        chk("R1", "lo", lo_out, 32'h0);
        chk("R1", "busy", {31'h0, busy}, 32'h0);
        chk("R1", "done", {31'h0, done}, 32'h0);

        // R11 move-to writes
        preset(32'hCAFE0001, 32'hBEEF0002);
        chk("R11", "hi move", hi_out, 32'hCAFE0001);
        chk("R11", "lo move", lo_out, 32'hBEEF0002);

        // Vector table: R2 R3 R4 R6
        for (int i = 0; i < NV; i++) begin
            logic [130:0] v;
            v = VEC[i];
            preset(v[63:32], v[31:0]);
            exp = ref_model(v[130:128], v[127:96], v[95:64], v[63:32], v[31:0]);
            issue(v[130:128], v[127:96], v[95:64]);
            wait_idle(cyc);
            chk(req_of(v[130:128]), $sformatf("vec %0d hi", i), hi_out, exp[63:32]);
            chk(req_of(v[130:128]), $sformatf("vec %0d lo", i), lo_out, exp[31:0]);
        end

        // R5 multiply timing
        issue(3'd1, 32'h00000010, 32'h00000020);
        chk("R5", "done after accept", {31'h0, done}, 32'h1);
        chk("R5", "busy low", {31'h0, busy}, 32'h0);
        chk("R5", "lo result", lo_out, 32'h00000200);
        @(negedge clk);
        chk("R5", "done drops", {31'h0, done}, 32'h0);

        // R7 divide timing
        issue(3'd7, 32'd1000, 32'd7);
        wait_idle(cyc);
        chk("R7", "busy cycles", cyc, 32);
        chk("R7", "done at end", {31'h0, done}, 32'h1);
        chk("R7", "quotient", lo_out, 32'd142);
        chk("R7", "remainder", hi_out, 32'd6);
        @(negedge clk);
        chk("R7", "done one cycle", {31'h0, done}, 32'h0);

        // R8 zero divisor
        preset(32'h0000ABCD, 32'h00001234);
        issue(3'd6, 32'h00000055, 32'h0);
        wait_idle(cyc);
        chk("R8", "busy cycles", cyc, 32);
        chk("R8", "done", {31'h0, done}, 32'h1);
        chk("R8", "hi kept", hi_out, 32'h0000ABCD);
        chk("R8", "lo kept", lo_out, 32'h00001234);

        // R9 most negative over minus one
        issue(3'd6, 32'h80000000, 32'hFFFFFFFF);
        wait_idle(cyc);
        chk("R9", "quotient", lo_out, 32'h80000000);
        chk("R9", "remainder", hi_out, 32'h00000000);

        // R10 starts during busy are ignored
        preset(32'h0000AAAA, 32'h00005555);
        issue(3'd7, 32'd100, 32'd7);
        cyc = 1;
        repeat (3) begin @(negedge clk); cyc++; end
        start = 1'b1; op = 3'd1; src_a = 32'd3; src_b = 32'd3;
        @(negedge clk); cyc++;
        start = 1'b0;
        chk("R10", "hi held", hi_out, 32'h0000AAAA);
        chk("R10", "lo held", lo_out, 32'h00005555);
        chk("R10", "still busy", {31'h0, busy}, 32'h1);
        start = 1'b1; op = 3'd7; src_a = 32'd9; src_b = 32'd3;
        @(negedge clk); cyc++;
        start = 1'b0;
        while (busy && cyc < 100) begin @(negedge clk); cyc++; end
        chk("R10", "window", cyc - 1, 32);
        chk("R10", "quotient", lo_out, 32'd14);
        chk("R10", "remainder", hi_out, 32'd2);
        @(negedge clk);
        chk("R10", "no second run", {31'h0, busy}, 32'h0);

        // R11 result wins over same-edge move-to
        @(negedge clk);
        start = 1'b1; op = 3'd1; src_a = 32'd2; src_b = 32'd3;
        hi_wr = 1'b1; lo_wr = 1'b1; wr_data = 32'hDEADDEAD;
        @(negedge clk);
        start = 1'b0; hi_wr = 1'b0; lo_wr = 1'b0;
        chk("R11", "hi priority", hi_out, 32'h0);
        chk("R11", "lo priority", lo_out, 32'd6);

        $display("%0d/%0d checks passed", total - fails, total);
        $finish;
    end

endmodule